// File: doc/BRIEF.md
# Dual-Channel DAC Trigger Interface

This block is the digital front end that sits between a register port and a two-channel digital-to-analog converter. Samples are written into one holding register per channel, in an 8-bit or a 12-bit format. The 12-bit format is accepted right or left justified within the bus word. Three dual-channel addresses let one write load both channels in the same cycle. Each channel then moves its held sample into the output code register that drives the converter. The move happens either straight after the write or only when a chosen trigger fires.

A single control word configures both channels. Channel 0 uses the low half and channel 1 the high half. Each half holds an enable, a trigger-enable, a 3-bit trigger source and a DMA enable. Triggers come from seven hardware lines, which are edge-detected inside the block, or from a per-channel software trigger bit that clears itself. A trigger that finds no fresh sample raises a sticky underrun flag. A trigger on a channel with DMA enabled raises that channel's request line. The next sample write drops the request again.

Top module: `dac_trig_if`

## Requirements
- R1: After reset both output codes are 0, both DMA requests are low, and the control word and status word read 0.
- R2: Address 0 is the control word, read back masked to its fields. Channel 0 uses bit 0 enable, bit 1 trigger enable, bits 4:2 trigger source and bit 5 DMA enable. Channel 1 uses the same fields shifted up by 16.
- R3: Single-channel writes go to addresses 2/3/4 for channel 0 and 5/6/7 for channel 1. The formats are, in that order, 12-bit right (data[11:0]), 12-bit left (data[15:4]) and 8-bit right (data[7:0], which becomes code {data[7:0],4'h0}).
- R4: Dual writes load both channels in the same cycle. Address 8 takes data[11:0] and data[27:16]. Address 9 takes data[15:4] and data[31:20]. Address 10 takes data[7:0] and data[15:8], each expanded as in R3.
- R5: With enable 1 and trigger enable 0, the output code takes the written sample at the second clock edge after the write is sampled, and not at the first.
- R6: With trigger enable 1, a write does not move the output code. A rising edge on trig_i[s], where s is the source value 0..6, moves it. The edge is registered at the first clock edge that sees the line high, and the output code changes at the following edge. Edges on other lines have no effect.
- R7: Source value 7 selects the software trigger. Writing 1 to bit c of address 1 sets channel c's trigger bit. The bit reads 1 for one cycle, then clears itself as the transfer is made.
- R8: A trigger with no sample written since the last transfer leaves the output code unchanged and sets status bit c at address 13. Writing 1 to that bit clears it.
- R9: When DMA enable is set, each trigger raises dma_req_o[c]. The next holding write to channel c lowers it.
- R10: A channel with enable 0 ignores both writes and triggers, and its output code holds.
- R11: Triggers on a channel whose trigger enable is 0 are ignored: no transfer and no underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address (combinational read) |
| rd_data_o | output | 32 | Read data |
| trig_i | input | 7 | Hardware trigger lines, sources 0..6 |
| dac0_code_o | output | 12 | Channel 0 converter code |
| dac1_code_o | output | 12 | Channel 1 converter code |
| dma_req_o | output | 2 | Per-channel DMA request |

## Verification
Every one of the nine write addresses is driven with asymmetric data, so that a swapped channel, a wrong bit slice or a dropped 8-bit shift shows up as a different code. The output code is sampled in the cycle before the transfer and in the cycle after it. This separates the immediate path from the trigger path and catches a one-cycle slip. Trigger tests pulse the selected line, an unselected line and a repeated line with no new data. This separates source decoding, edge gating and underrun detection. The software trigger, the disabled channel and trigger-enable 0 are each tried against a pending sample, so that an ignored stimulus would visibly change the output code.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;
  localparam int CODE_W = 12;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int TSEL_W = 3;
  localparam int N_HW   = (1 << TSEL_W) - 1;
  localparam int N_CH   = 2;
  localparam int CFG_W  = TSEL_W + 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 4'd0,
    A_SWTRG = 4'd1,
    A_R12_0 = 4'd2,
    A_L12_0 = 4'd3,
    A_R8_0  = 4'd4,
    A_R12_1 = 4'd5,
    A_L12_1 = 4'd6,
    A_R8_1  = 4'd7,
    A_R12_D = 4'd8,
    A_L12_D = 4'd9,
    A_R8_D  = 4'd10,
    A_CODE0 = 4'd11,
    A_CODE1 = 4'd12,
    A_STAT  = 4'd13
  } addr_e;

  typedef struct packed {
    logic              dma_en;
    logic [TSEL_W-1:0] tsel;
    logic              ten;
    logic              en;
  } chcfg_t;
endpackage

// File: rtl/dac_wr_unpack.sv
module dac_wr_unpack
  import dac_trig_pkg::*;
(
  input  logic                         wr_en_i,
  input  addr_e                        wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic [N_CH-1:0]              ld_o,
  output logic [N_CH-1:0][CODE_W-1:0]  val_o
);
  logic [DATA_W-1:0] d;
  assign d = wr_data_i;

  always_comb begin
    ld_o  = '0;
    val_o = '0;
    if (wr_en_i) begin
      unique case (wr_addr_i)
        A_R12_0: begin ld_o = 2'b01; val_o[0] = d[11:0]; end
        A_L12_0: begin ld_o = 2'b01; val_o[0] = d[15:4]; end
        A_R8_0:  begin ld_o = 2'b01; val_o[0] = {d[7:0], 4'h0}; end
        A_R12_1: begin ld_o = 2'b10; val_o[1] = d[11:0]; end
        A_L12_1: begin ld_o = 2'b10; val_o[1] = d[15:4]; end
        A_R8_1:  begin ld_o = 2'b10; val_o[1] = {d[7:0], 4'h0}; end
        A_R12_D: begin ld_o = 2'b11; val_o[0] = d[11:0];  val_o[1] = d[27:16]; end
        A_L12_D: begin ld_o = 2'b11; val_o[0] = d[15:4];  val_o[1] = d[31:20]; end
        A_R8_D:  begin ld_o = 2'b11; val_o[0] = {d[7:0], 4'h0}; val_o[1] = {d[15:8], 4'h0}; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dac_trig_det.sv
module dac_trig_det
  import dac_trig_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_HW-1:0]               trig_i,
  input  logic [N_CH-1:0]               sw_set_i,
  input  logic [N_CH-1:0][TSEL_W-1:0]   sel_i,
  output logic [N_CH-1:0]               sw_q_o,
  output logic [N_CH-1:0]               evt_o
);
  logic [N_HW-1:0] prev_q, det_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      det_q  <= '0;
      sw_q_o <= '0;
    end else begin
      prev_q <= trig_i;
      det_q  <= trig_i & ~prev_q;
      sw_q_o <= sw_set_i;   // one-cycle pulse: self-clearing
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_sel
    logic [N_HW:0] src;
    assign src      = {sw_q_o[c], det_q};
    assign evt_o[c] = src[sel_i[c]];
  end
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_trig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  chcfg_t            cfg_i,
  input  logic              ld_i,
  input  logic [CODE_W-1:0] val_i,
  input  logic              evt_i,
  input  logic              udr_clr_i,
  output logic [CODE_W-1:0] code_o,
  output logic              udr_o,
  output logic              dma_o
);
  logic [CODE_W-1:0] hold_q;
  logic              fresh_q, imm_q, wr_ok, fire;

  assign wr_ok = ld_i & cfg_i.en;
  assign fire  = evt_i & cfg_i.en & cfg_i.ten;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      fresh_q <= 1'b0;
      imm_q   <= 1'b0;
      code_o  <= '0;
      udr_o   <= 1'b0;
      dma_o   <= 1'b0;
    end else begin
      imm_q <= wr_ok & ~cfg_i.ten;
      if (wr_ok) hold_q <= val_i;

      if (imm_q || (fire && fresh_q)) code_o <= hold_q;

      if (wr_ok)                fresh_q <= 1'b1;
      else if (fire || imm_q)   fresh_q <= 1'b0;

      if (fire && !fresh_q)     udr_o <= 1'b1;
      else if (udr_clr_i)       udr_o <= 1'b0;

      if (fire && cfg_i.dma_en) dma_o <= 1'b1;
      else if (wr_ok)           dma_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_trig_if.sv
module dac_trig_if
  import dac_trig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [N_HW-1:0]   trig_i,
  output logic [CODE_W-1:0] dac0_code_o,
  output logic [CODE_W-1:0] dac1_code_o,
  output logic [N_CH-1:0]   dma_req_o
);
  localparam int HALF = DATA_W / 2;

  addr_e                        wa, ra;
  chcfg_t [N_CH-1:0]            cfg_q;
  logic   [N_CH-1:0]            hold_ld, trig_evt, sw_q, sw_set, udr_clr, udr_q;
  logic   [N_CH-1:0][CODE_W-1:0] hold_val, code;
  logic   [N_CH-1:0][TSEL_W-1:0] sel;

  assign wa = addr_e'(wr_addr_i);
  assign ra = addr_e'(rd_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (wr_en_i && wa == A_CTRL)
      for (int c = 0; c < N_CH; c++) cfg_q[c] <= wr_data_i[c*HALF +: CFG_W];
  end

  assign sw_set  = (wr_en_i && wa == A_SWTRG) ? wr_data_i[N_CH-1:0] : '0;
  assign udr_clr = (wr_en_i && wa == A_STAT)  ? wr_data_i[N_CH-1:0] : '0;

  dac_wr_unpack u_unpack (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wa),
    .wr_data_i(wr_data_i),
    .ld_o     (hold_ld),
    .val_o    (hold_val)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_sel
    assign sel[c] = cfg_q[c].tsel;
  end

  dac_trig_det u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig_i),
    .sw_set_i(sw_set),
    .sel_i   (sel),
    .sw_q_o  (sw_q),
    .evt_o   (trig_evt)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dac_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cfg_i    (cfg_q[c]),
      .ld_i     (hold_ld[c]),
      .val_i    (hold_val[c]),
      .evt_i    (trig_evt[c]),
      .udr_clr_i(udr_clr[c]),
      .code_o   (code[c]),
      .udr_o    (udr_q[c]),
      .dma_o    (dma_req_o[c])
    );
  end

  assign dac0_code_o = code[0];
  assign dac1_code_o = code[1];

  always_comb begin
    rd_data_o = '0;
    unique case (ra)
      A_CTRL:  for (int c = 0; c < N_CH; c++) rd_data_o[c*HALF +: CFG_W] = cfg_q[c];
      A_SWTRG: rd_data_o[N_CH-1:0] = sw_q;
      A_CODE0: rd_data_o[CODE_W-1:0] = code[0];
      A_CODE1: rd_data_o[CODE_W-1:0] = code[1];
      A_STAT:  rd_data_o[N_CH-1:0] = udr_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/dac_trig_if_chk.sv
module dac_trig_if_chk
  import dac_trig_pkg::*;
(
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic [ADDR_W-1:0]             wr_addr_i,
  input logic [DATA_W-1:0]             wr_data_i,
  input logic [N_CH-1:0][CFG_W-1:0]    cfg_q,
  input logic [N_CH-1:0]               hold_ld,
  input logic [N_CH-1:0]               trig_evt,
  input logic [N_CH-1:0]               sw_q,
  input logic [N_CH-1:0]               udr_q,
  input logic [N_CH-1:0]               dma_req_o,
  input logic [N_CH-1:0][CODE_W-1:0]   code
);
  logic sw_wr;
  assign sw_wr = wr_en_i && (wr_addr_i == 4'd1);

  for (genvar c = 0; c < N_CH; c++) begin : g_a
    assert_sw_from_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sw_q[c] |-> $past(sw_wr && wr_data_i[c]));
    assert_udr_needs_trig_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(udr_q[c]) |-> $past(trig_evt[c] && cfg_q[c][0] && cfg_q[c][1]));
    assert_dma_drop_on_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(dma_req_o[c]) |-> $past(hold_ld[c]));
    assert_code_frozen_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(code[c]) |-> $past(cfg_q[c][0]));
    assert_no_udr_imm_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_q[c][1] && !udr_q[c]) |=> !udr_q[c]);
  end
endmodule

bind dac_trig_if dac_trig_if_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .cfg_q    (cfg_q),
  .hold_ld  (hold_ld),
  .trig_evt (trig_evt),
  .sw_q     (sw_q),
  .udr_q    (udr_q),
  .dma_req_o(dma_req_o),
  .code     (code)
);

// File: tb/dac_trig_if_tb.sv
module dac_trig_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [6:0]  trig = '0;
  logic [11:0] code0, code1;
  logic [1:0]  dma;

  int cyc = 0, n_run = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {int due; int kind; logic [31:0] exp; string req;} item_t;
  item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  dac_trig_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .trig_i(trig), .dac0_code_o(code0), .dac1_code_o(code1), .dma_req_o(dma)
  );

  // kind: 0 code0, 1 code1, 2 dma, 3 rd_data
  task automatic expect_at(int kind, logic [31:0] exp, string req, int dly);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk); #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = 32'(code0);
          1: act = 32'(code1);
          2: act = 32'(dma);
          default: act = rd_data;
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d act=%h exp=%h cyc=%0d", it.req, it.kind, act, it.exp, cyc);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    rd_addr = a;
    expect_at(3, exp, req, 0);
    tick(1);
  endtask

  // immediate write: code unchanged one edge after, updated the next
  task automatic imm(logic [3:0] a, logic [31:0] d, logic [11:0] o0, logic [11:0] o1,
                     logic [11:0] n0, logic [11:0] n1, string req);
    wr(a, d);
    expect_at(0, 32'(o0), req, 0);
    expect_at(1, 32'(o1), req, 0);
    expect_at(0, 32'(n0), req, 1);
    expect_at(1, 32'(n1), req, 1);
    tick(2);
  endtask

  task automatic pulse(int line);
    trig[line] = 1'b1;
    tick(1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1
    expect_at(0, 0, "R1", 0); expect_at(1, 0, "R1", 0); expect_at(2, 0, "R1", 0);
    rd(4'd0, 0, "R1");
    rd(4'd13, 0, "R1");
    // R2 readback with masking
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, 32'h003F_003F, "R2");
    wr(4'd0, 32'h0001_0001);
    rd(4'd0, 32'h0001_0001, "R2");
    // R3 / R5 single formats
    imm(4'd2, 32'h0000_0ABC, 12'h000, 12'h000, 12'hABC, 12'h000, "R5_R3");
    imm(4'd3, 32'h0000_DEF0, 12'hABC, 12'h000, 12'hDEF, 12'h000, "R3");
    imm(4'd4, 32'h0000_005A, 12'hDEF, 12'h000, 12'h5A0, 12'h000, "R3");
    imm(4'd5, 32'h0000_0123, 12'h5A0, 12'h000, 12'h5A0, 12'h123, "R3");
    imm(4'd6, 32'h0000_4560, 12'h5A0, 12'h123, 12'h5A0, 12'h456, "R3");
    imm(4'd7, 32'h0000_007F, 12'h5A0, 12'h456, 12'h5A0, 12'h7F0, "R3");
    // R4 dual formats
    imm(4'd8,  32'h0321_0654, 12'h5A0, 12'h7F0, 12'h654, 12'h321, "R4");
    imm(4'd9,  32'h9870_CBA0, 12'h654, 12'h321, 12'hCBA, 12'h987, "R4");
    imm(4'd10, 32'h0000_3C1E, 12'hCBA, 12'h987, 12'h1E0, 12'h3C0, "R4");
    // R6: ch0 en+ten, source 2, dma; ch1 en+ten, source 7 (software)
    wr(4'd0, 32'h001F_002B);
    wr(4'd2, 32'h0000_0111);
    expect_at(0, 32'h1E0, "R6", 0);
    expect_at(0, 32'h1E0, "R6", 2);
    tick(3);
    pulse(3); trig[3] = 1'b0;
    tick(2);
    expect_at(0, 32'h1E0, "R6", 0);
    tick(1);
    pulse(2);
    expect_at(0, 32'h1E0, "R6", 0);
    expect_at(0, 32'h111, "R6", 1);
    expect_at(2, 32'h1, "R9", 1);
    trig[2] = 1'b0;
    tick(3);
    // R8 underrun on repeated edge
    pulse(2); trig[2] = 1'b0;
    tick(2);
    expect_at(0, 32'h111, "R8", 0);
    rd(4'd13, 32'h1, "R8");
    wr(4'd13, 32'h1);
    rd(4'd13, 32'h0, "R8");
    // R9 clear on write
    wr(4'd2, 32'h0000_0222);
    expect_at(2, 32'h0, "R9", 0);
    tick(1);
    // R7 software trigger on ch1
    wr(4'd5, 32'h0000_0333);
    rd_addr = 4'd1;
    wr(4'd1, 32'h0000_0002);
    expect_at(3, 32'h2, "R7", 0);
    expect_at(1, 32'h3C0, "R7", 0);
    expect_at(3, 32'h0, "R7", 1);
    expect_at(1, 32'h333, "R7", 1);
    tick(2);
    // R11: ch0 trigger enable off, source 2; pending 0x222 must not move
    wr(4'd0, 32'h001F_0009);
    pulse(2); trig[2] = 1'b0;
    tick(3);
    expect_at(0, 32'h111, "R11", 0);
    rd(4'd13, 32'h0, "R11");
    // R10: ch0 disabled, write and triggers ignored
    wr(4'd0, 32'h001F_0000);
    wr(4'd2, 32'h0000_0444);
    wr(4'd1, 32'h0000_0001);
    pulse(0); trig[0] = 1'b0;
    tick(3);
    expect_at(0, 32'h111, "R10", 0);
    rd(4'd11, 32'h111, "R10");
    rd(4'd13, 32'h0, "R10");
    tick(3);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard not drained: %0d left, expected 0", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule